// File: doc/BRIEF.md
# Parallel Disk Register-Cycle Sequencer (programmed I/O, host side)

This block runs one 16-bit programmed-I/O cycle at a time on the host end of a parallel disk interface. A client offers a request through a valid/ready handshake. The request carries the direction, a small register address and, for a write, the data word. The sequencer places the address on the bus and drives the active-low read or write strobe. For a write it also drives the data bus. All intervals are counted in system clocks. Each minimum time is a nanosecond parameter that is converted to a clock count by rounding up against the clock period.

The device may hold the ready line low to stretch the strobe. That line passes through a two-flop synchronizer, and the minimum pulse length is lengthened so that an early wait request from the device is always seen. If the device keeps the line low past the allowed maximum, the cycle ends anyway and the completion is marked as a timeout. On the edge that raises the strobe, the read word is captured. A one-cycle completion pulse then presents that word. The sequencer accepts a new request only after the recovery time and the full-cycle minimum have both been met.

Top module: `ata_pio_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, both strobes are high, the data bus is not driven, req_ready is 1 and done is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. That edge loads bus_addr. bus_addr then stays unchanged until the next acceptance. The strobe falls SU = ceil(T_ASU_NS/CLK_NS) edges after the acceptance edge.
- R3: A read lowers only bus_rd_n and a write lowers only bus_wr_n. The two strobes are never low together.
- R4: The strobe stays low for at least PMIN = max(ceil(T_PULSE_NS/CLK_NS), ceil(T_RDY_NS/CLK_NS)+2) cycles.
- R5: The IORDY level present at clock edge n is acted on at edge n+2. Once PMIN cycles have passed, the strobe rises at the first edge where that delayed level is high.
- R6: The pulse ends at cycle count PMIN+WT, where WT = ceil(T_WAIT_NS/CLK_NS). If the delayed IORDY is still low at that edge, the pulse ends and done_timeout is 1 with the completion. Otherwise done_timeout is 0.
- R7: bus_din is captured on the edge that raises the strobe. In the following cycle, done is high for exactly one cycle and done_rdata carries that word.
- R8: For a write, bus_doe and bus_dout (the request data) are driven from acceptance until HD = ceil(T_HOLD_NS/CLK_NS) edges after the strobe rises. After that, bus_doe is 0.
- R9: req_ready returns max(SU+P+RM, CY-1) edges after acceptance. Here P is the actual pulse length, RM = max(ceil(T_REC_NS/CLK_NS), HD) and CY = ceil(T_CYC_NS/CLK_NS). As a result, two acceptances are at least CY cycles apart.
- R10: While req_ready is 0, req_valid and the request fields have no effect, and bus_addr and bus_dout keep the accepted values.

Write data is launched together with the address. Its setup before the write strobe rises is therefore SU+P cycles, which always exceeds the data setup minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Register address for the cycle |
| req_wdata | input | DATA_W | Write data |
| bus_addr | output | ADDR_W | Address lines to the device |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | DATA_W | Data driven toward the device |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | Data bus as seen from the device |
| bus_iordy | input | 1 | Device ready, low requests a wait (asynchronous) |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Word captured on a read |
| done_timeout | output | 1 | Completion ended by the wait limit |

## Verification
The assertions assume that the device first pulls IORDY low no later than ceil(T_RDY_NS/CLK_NS)-1 cycles into the strobe pulse. This is what lets PMIN cover the synchronizer delay. They also assume IORDY is high whenever no pulse is in progress. The stimulus drives IORDY only at falling clock edges. Every wait window it uses starts between pulse cycles 0 and 3. It raises IORDY again once each transfer completes. Within those limits, the windows cover these cases: a window that ends before the minimum pulse, one that stretches the pulse by a single cycle, a long stretch, a window that ends exactly one cycle before the limit, and one that runs past the limit.

// File: rtl/ata_pio_seq.sv
module ata_pio_seq #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int CLK_NS      = 10,
  parameter int T_CYC_NS    = 120,
  parameter int T_ASU_NS    = 25,
  parameter int T_PULSE_NS  = 70,
  parameter int T_REC_NS    = 25,
  parameter int T_HOLD_NS   = 10,
  parameter int T_RDY_NS    = 35,
  parameter int T_WAIT_NS   = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_iordy,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata,
  output logic              done_timeout
);

  localparam int SU_RAW = (T_ASU_NS   + CLK_NS - 1) / CLK_NS;
  localparam int PW_RAW = (T_PULSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC_RAW = (T_REC_NS   + CLK_NS - 1) / CLK_NS;
  localparam int HD_RAW = (T_HOLD_NS  + CLK_NS - 1) / CLK_NS;
  localparam int CY_C   = (T_CYC_NS   + CLK_NS - 1) / CLK_NS;
  localparam int RDY_C  = (T_RDY_NS   + CLK_NS - 1) / CLK_NS;
  localparam int WT_C   = (T_WAIT_NS  + CLK_NS - 1) / CLK_NS;
  localparam int SU_C   = (SU_RAW < 1) ? 1 : SU_RAW;
  localparam int PW_C   = (PW_RAW < 1) ? 1 : PW_RAW;
  localparam int HD_C   = (HD_RAW < 1) ? 1 : HD_RAW;
  localparam int P_MIN  = (PW_C > RDY_C + 2) ? PW_C : RDY_C + 2;
  localparam int R_MIN  = (RC_RAW > HD_C) ? RC_RAW : HD_C;
  localparam int CY_LAST  = (CY_C > 2) ? CY_C - 2 : 0;
  localparam int TMO_LAST = P_MIN - 1 + WT_C;
  localparam int CNT_W  = $clog2(SU_C + TMO_LAST + R_MIN + CY_C + 4) + 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE, S_RECOV} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, tot;
  logic             rdy_m, rdy_s, wr_q;

  assign req_ready = (st == S_IDLE);

  wire pulse_min_ok = cnt >= CNT_W'(P_MIN - 1);
  wire tmo_hit      = cnt == CNT_W'(TMO_LAST);
  wire pulse_end    = pulse_min_ok && (rdy_s || tmo_hit);
  wire rec_end      = (cnt >= CNT_W'(R_MIN - 1)) && (tot >= CNT_W'(CY_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      tot          <= '0;
      rdy_m        <= 1'b1;
      rdy_s        <= 1'b1;
      wr_q         <= 1'b0;
      bus_addr     <= '0;
      bus_dout     <= '0;
      bus_doe      <= 1'b0;
      bus_rd_n     <= 1'b1;
      bus_wr_n     <= 1'b1;
      done         <= 1'b0;
      done_rdata   <= '0;
      done_timeout <= 1'b0;
    end else begin
      rdy_m <= bus_iordy;
      rdy_s <= rdy_m;
      done  <= 1'b0;
      if (st != S_IDLE) tot <= tot + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          bus_addr <= req_addr;
          bus_dout <= req_wdata;
          bus_doe  <= req_write;
          wr_q     <= req_write;
          cnt      <= '0;
          tot      <= '0;
          st       <= S_SETUP;
        end
        S_SETUP: if (cnt == CNT_W'(SU_C - 1)) begin
          cnt      <= '0;
          bus_rd_n <= wr_q;
          bus_wr_n <= !wr_q;
          st       <= S_PULSE;
        end else cnt <= cnt + 1'b1;
        S_PULSE: if (pulse_end) begin
          bus_rd_n     <= 1'b1;
          bus_wr_n     <= 1'b1;
          done         <= 1'b1;
          done_rdata   <= bus_din;
          done_timeout <= !rdy_s;
          cnt          <= '0;
          st           <= S_RECOV;
        end else cnt <= cnt + 1'b1;
        S_RECOV: begin
          if (cnt == CNT_W'(HD_C - 1)) bus_doe <= 1'b0;
          if (rec_end) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  a_r2_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $stable(bus_addr));

  a_r10_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ($stable(bus_addr) && $stable(bus_dout)));

  a_r4_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> ($past(cnt) >= CNT_W'(P_MIN - 1)));

  a_r7_done_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(bus_rd_n) || $rose(bus_wr_n)));

  a_r6_timeout_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_timeout) |-> $past(!rdy_s));

endmodule

// File: tb/ata_pio_seq_bench.sv
module ata_pio_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_CYC   = 180;
  localparam int SU   = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int PW   = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RDY  = (35 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int PMIN = (PW > RDY + 2) ? PW : RDY + 2;
  localparam int HD   = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RC   = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RM   = (RC > HD) ? RC : HD;
  localparam int CY   = (T_CYC + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WT   = (1250 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int TMO  = PMIN - 1 + WT;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [2:0]  req_addr = '0, bus_addr;
  logic [15:0] req_wdata = '0, bus_dout, bus_din = '0, done_rdata;
  logic        bus_rd_n, bus_wr_n, bus_doe, bus_iordy = 1'b1, done, done_timeout;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_pio_seq #(.T_CYC_NS(T_CYC)) u_ata_pio_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_iordy(bus_iordy), .done(done), .done_rdata(done_rdata),
    .done_timeout(done_timeout));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic bit low_seen(input int j, input int l0, input int llen);
    return (llen > 0) && (j >= l0 + 2) && (j <= l0 + llen + 1);
  endfunction

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req_ready === 1'b1, "R9", "ready idle", req_ready, 1);
      chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R3", "strobes idle", {bus_rd_n, bus_wr_n}, 3);
      chk(done === 1'b0, "R7", "done idle", done, 0);
    end
  endtask

  task automatic xfer(input bit wr, input logic [2:0] a, input logic [15:0] wd,
                      input logic [15:0] rw, input int l0, input int llen, input bit junk);
    int j, p, rex, xoff, c;
    bit tmo, exp_lo;
    j = PMIN - 1;
    while (low_seen(j, l0, llen) && j < TMO) j++;
    tmo  = low_seen(j, l0, llen);
    p    = j + 1;
    rex  = RM - 1;
    if (CY - 2 - SU - p > rex) rex = CY - 2 - SU - p;
    xoff = SU + p + rex + 1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; bus_din = ~rw;
    @(posedge clk);
    for (int m = 0; m <= xoff; m++) begin
      @(negedge clk);
      exp_lo = (m >= SU) && (m < SU + p);
      chk(bus_rd_n === !(exp_lo && !wr), "R4 R5 R6", "rd strobe", bus_rd_n, !(exp_lo && !wr));
      chk(bus_wr_n === !(exp_lo && wr), "R2 R3", "wr strobe", bus_wr_n, !(exp_lo && wr));
      chk(bus_doe === (wr && m < SU + p + HD), "R8", "data enable", bus_doe, wr && m < SU + p + HD);
      chk(req_ready === (m >= xoff), "R9", "ready", req_ready, m >= xoff);
      chk(done === (m == SU + p), "R7", "done pulse", done, m == SU + p);
      chk(bus_addr === a, "R10", "address hold", bus_addr, a);
      if (bus_doe) chk(bus_dout === wd, "R10", "write data", bus_dout, wd);
      if (m == SU + p) begin
        chk(done_timeout === tmo, "R6", "timeout flag", done_timeout, tmo);
        if (!wr) chk(done_rdata === rw, "R7", "read word", done_rdata, rw);
      end
      req_valid = junk && (m < xoff);
      req_write = !wr; req_addr = ~a; req_wdata = ~wd;
      c = m - SU;
      bus_iordy = !((c >= l0) && (c < l0 + llen));
      bus_din = (m == SU + p - 1) ? rw : (~rw ^ 16'(m));
    end
    req_valid = 1'b0;
    bus_iordy = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0, "R1", "reset ready/done", {req_ready, done}, 2);
    chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1 && bus_doe === 1'b0, "R1", "reset bus",
        {bus_rd_n, bus_wr_n, bus_doe}, 6);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && bus_rd_n === 1'b1 && bus_wr_n === 1'b1 && bus_doe === 1'b0,
        "R1", "after reset", {req_ready, bus_rd_n, bus_wr_n, bus_doe}, 14);
    xfer(1'b0, 3'd1, 16'h0000, 16'hA55A, 0, 0, 1'b0);
    xfer(1'b1, 3'd6, 16'h1234, 16'h0000, 3, 10, 1'b1);
    idle_cycles(2);
    xfer(1'b0, 3'd7, 16'h0000, 16'h0F0F, 0, 2, 1'b1);
    xfer(1'b0, 3'd2, 16'h0000, 16'hBEEF, 2, 3, 1'b0);
    xfer(1'b1, 3'd5, 16'hC3C3, 16'h0000, 0, 0, 1'b0);
    xfer(1'b0, 3'd3, 16'h0000, 16'h7E81, 1, 128, 1'b0);
    idle_cycles(3);
    xfer(1'b0, 3'd4, 16'h0000, 16'h5AA5, 1, 129, 1'b1);
    xfer(1'b1, 3'd0, 16'hFFFF, 16'h0000, 1, 300, 1'b0);
    idle_cycles(4);
    xfer(1'b0, 3'd6, 16'h0000, 16'h8001, 0, 0, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule